// File: doc/BRIEF.md
# Result Signature Checker with Crash Detection

This block watches the parallel output port of a target computer. At the end of each program cycle the target writes a 16-bit signature that sums up that cycle's results. The checker compares each signature with a reference value loaded from outside. A signature that equals the reference counts as a correct result. A signature that differs counts as a wrong result, which is a fail-silent violation. If the target goes quiet for longer than a programmable number of clock cycles, the checker reports a crash. A crash is a separate outcome from a wrong result.

The write strobe is asynchronous to the checker clock, so it passes through a synchroniser first. The port data is captured once, on each rising edge of the synchronised strobe.

A control state machine drives everything. It has three states:
- `ST_IDLE`: the checker is disarmed.
- `ST_WATCH`: the checker is armed and the timeout window is counting down.
- `ST_SILENT`: the checker is armed, a crash has been reported, and it is waiting for the target to write again.

Its transitions are:
- ARM: `ST_IDLE` to `ST_WATCH` when the arm input is high. This loads the window.
- EXPIRE: `ST_WATCH` to `ST_SILENT` when the window runs out with no strobe.
- RESUME: `ST_SILENT` to `ST_WATCH` on a strobe. The strobe is compared and the window is reloaded.
- ACCEPT: `ST_WATCH` to `ST_WATCH` on a strobe. The strobe is compared and the window is reloaded.
- DISARM: any state to `ST_IDLE` when the arm input is low.

The checker raises sticky flags and keeps three saturating event counters. It also latches which kind of fault came first.

Top module: `sig_result_checker`

## Requirements
- R1: After reset the checker behaves as follows:
  - both flags are low;
  - the outcome code is 2'b00 (none);
  - all three counters read zero;
  - the machine is in `ST_IDLE`.
- R2: Exactly one comparison is made for each rising edge of the strobe, however long the strobe stays high.
- R3: While armed, a captured signature equal to `ref_sig_i` increments `match_count_o` by one. It sets no flag.
- R4: While armed, a captured signature that differs from `ref_sig_i` in any bit does two things:
  - it increments `mismatch_count_o` by one;
  - it sets `mismatch_flag_o`, which then stays high.
- R5: The window is set by `window_i`, a value T in clock cycles. If T is sampled when arming, `crash_flag_o` is still low T clock edges after the arming edge and is high one edge later. `crash_count_o` then increments once. It increments only once for each silent stretch, however long the stretch lasts.
- R6: Each accepted strobe reloads the window from `window_i`. Strobes spaced closer than the window never cause a crash.
- R7: In `ST_SILENT`, the next strobe is compared as usual and the machine returns to `ST_WATCH`. A later silent stretch counts as another crash.
- R8: While `arm_i` is low, strobes change no counter or flag and no crash is raised. Re-arming starts a full new window.
- R9: `outcome_o` latches the first fault after reset or clear: 2'b01 for a wrong result, 2'b10 for a crash. It holds until cleared, whatever fault comes later.
- R10: A high `clear_i` at a clock edge zeroes both flags, the outcome and all three counters. This takes priority over an event at the same edge.
- R11: Each counter stops at its all-ones value (`CNT_W` bits) and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Checker clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | High enables checking; low disarms |
| clear_i | input | 1 | Clears flags, outcome and counters |
| strobe_i | input | 1 | Asynchronous write strobe from the target port |
| port_data_i | input | SIG_W | Signature on the target's output port |
| ref_sig_i | input | SIG_W | Expected signature |
| window_i | input | WIN_W | Crash timeout in clock cycles |
| mismatch_flag_o | output | 1 | Sticky wrong-result flag |
| crash_flag_o | output | 1 | Sticky crash flag |
| outcome_o | output | 2 | First fault: 00 none, 01 wrong, 10 crash |
| match_count_o | output | CNT_W | Correct signatures seen |
| mismatch_count_o | output | CNT_W | Wrong signatures seen |
| crash_count_o | output | CNT_W | Crash events seen |

## Verification
The comparison is exercised with these signature patterns, and each one separates a different error:
- exact matches, including all zeros and all ones;
- a single low-bit difference;
- a difference in the top bit only;
- a fully inverted pattern.

A long strobe separates edge detection from level sensing. Strobes spaced just inside the window separate a reloading timer from a free-running one. The crash is sampled one edge before and one edge after the expected cycle, which exposes an off-by-one in the window. The fault order is run both ways (wrong then crash, and crash then wrong), and a clear is made to land on the same edge as a crash, to show which wins.

// File: rtl/sigchk_pkg.sv
package sigchk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_WATCH  = 2'b01,
        ST_SILENT = 2'b10
    } chk_state_e;

    typedef enum logic [1:0] {
        OUT_NONE  = 2'b00,
        OUT_WRONG = 2'b01,
        OUT_CRASH = 2'b10
    } run_outcome_e;

    localparam int unsigned EVT_MATCH    = 0;
    localparam int unsigned EVT_MISMATCH = 1;
    localparam int unsigned EVT_CRASH    = 2;
    localparam int unsigned EVT_NUM      = 3;

endpackage

// File: rtl/sigchk_strobe_sync.sv
module sigchk_strobe_sync #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DATA_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              pulse_o,
    output logic [DATA_W-1:0] data_o
);

    localparam int unsigned CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;
    logic               rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN_W-2:0], strobe_i};
        end
    end

    assign rise = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_o <= 1'b0;
            data_o  <= '0;
        end else begin
            pulse_o <= rise;
            if (rise) begin
                data_o <= data_i;
            end
        end
    end

    // R2: the captured pulse never lasts two cycles in a row
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);

endmodule

// File: rtl/sigchk_window_timer.sv
module sigchk_window_timer #(
    parameter int unsigned WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload_i,
    input  logic [WIN_W-1:0] load_val_i,
    input  logic             run_i,
    output logic             zero_o
);

    logic [WIN_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (reload_i) begin
            cnt_q <= load_val_i;
        end else if (run_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

    // R6: a reload takes the programmed window
    a_r6_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
        reload_i |=> (cnt_q == $past(load_val_i)));

    // R5: a running window steps down by exactly one
    a_r5_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !reload_i && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sigchk_sat_counter.sv
module sigchk_sat_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] count_o
);

    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (clr_i) begin
            count_o <= '0;
        end else if (inc_i && (count_o != TOP)) begin
            count_o <= count_o + 1'b1;
        end
    end

    // R11: a full counter stays full
    a_r11_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        ((count_o == TOP) && !clr_i) |=> (count_o == TOP));

    // R2: one event at most per edge
    a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((count_o == $past(count_o)) || (count_o == $past(count_o) + 1'b1)));

endmodule

// File: rtl/sig_result_checker.sv
module sig_result_checker
    import sigchk_pkg::*;
#(
    parameter int unsigned SIG_W       = 16,
    parameter int unsigned WIN_W       = 16,
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic             clear_i,
    input  logic             strobe_i,
    input  logic [SIG_W-1:0] port_data_i,
    input  logic [SIG_W-1:0] ref_sig_i,
    input  logic [WIN_W-1:0] window_i,
    output logic             mismatch_flag_o,
    output logic             crash_flag_o,
    output logic [1:0]       outcome_o,
    output logic [CNT_W-1:0] match_count_o,
    output logic [CNT_W-1:0] mismatch_count_o,
    output logic [CNT_W-1:0] crash_count_o
);

    chk_state_e       state_q, state_d;
    logic             pulse;
    logic [SIG_W-1:0] sample;
    logic             tmr_zero;
    logic             reload;
    logic             run;
    logic             ok_evt, wrong_evt, crash_evt;
    logic [EVT_NUM-1:0]            evt_vec;
    logic [EVT_NUM-1:0][CNT_W-1:0] cnt_vec;
    run_outcome_e     outcome_q;

    sigchk_strobe_sync #(
        .SYNC_STAGES (SYNC_STAGES),
        .DATA_W      (SIG_W)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (strobe_i),
        .data_i   (port_data_i),
        .pulse_o  (pulse),
        .data_o   (sample)
    );

    sigchk_window_timer #(
        .WIN_W (WIN_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .reload_i   (reload),
        .load_val_i (window_i),
        .run_i      (run),
        .zero_o     (tmr_zero)
    );

    // Next state and events
    always_comb begin
        state_d   = state_q;
        reload    = 1'b0;
        run       = 1'b0;
        ok_evt    = 1'b0;
        wrong_evt = 1'b0;
        crash_evt = 1'b0;
        if (!arm_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_WATCH;
                    reload  = 1'b1;
                end
                ST_WATCH: begin
                    run = 1'b1;
                    if (pulse) begin
                        reload    = 1'b1;
                        ok_evt    = (sample == ref_sig_i);
                        wrong_evt = (sample != ref_sig_i);
                    end else if (tmr_zero) begin
                        crash_evt = 1'b1;
                        state_d   = ST_SILENT;
                    end
                end
                ST_SILENT: begin
                    if (pulse) begin
                        reload    = 1'b1;
                        ok_evt    = (sample == ref_sig_i);
                        wrong_evt = (sample != ref_sig_i);
                        state_d   = ST_WATCH;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Sticky flags and first-fault outcome
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mismatch_flag_o <= 1'b0;
            crash_flag_o    <= 1'b0;
            outcome_q       <= OUT_NONE;
        end else if (clear_i) begin
            mismatch_flag_o <= 1'b0;
            crash_flag_o    <= 1'b0;
            outcome_q       <= OUT_NONE;
        end else begin
            if (wrong_evt) begin
                mismatch_flag_o <= 1'b1;
            end
            if (crash_evt) begin
                crash_flag_o <= 1'b1;
            end
            if (outcome_q == OUT_NONE) begin
                if (wrong_evt) begin
                    outcome_q <= OUT_WRONG;
                end else if (crash_evt) begin
                    outcome_q <= OUT_CRASH;
                end
            end
        end
    end

    assign outcome_o = outcome_q;

    assign evt_vec[EVT_MATCH]    = ok_evt;
    assign evt_vec[EVT_MISMATCH] = wrong_evt;
    assign evt_vec[EVT_CRASH]    = crash_evt;

    for (genvar g = 0; g < EVT_NUM; g++) begin : g_cnt
        sigchk_sat_counter #(
            .W (CNT_W)
        ) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_i   (clear_i),
            .inc_i   (evt_vec[g]),
            .count_o (cnt_vec[g])
        );
    end

    assign match_count_o    = cnt_vec[EVT_MATCH];
    assign mismatch_count_o = cnt_vec[EVT_MISMATCH];
    assign crash_count_o    = cnt_vec[EVT_CRASH];

    // R4: wrong-result flag is sticky
    a_r4_wrong_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (mismatch_flag_o && !clear_i) |=> mismatch_flag_o);

    // R5: crash flag is sticky
    a_r5_crash_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (crash_flag_o && !clear_i) |=> crash_flag_o);

    // R9: first fault holds until clear
    a_r9_outcome_held: assert property (@(posedge clk) disable iff (!rst_n)
        ((outcome_o != OUT_NONE) && !clear_i) |=> $stable(outcome_o));

    // R8: nothing is counted while disarmed
    a_r8_idle_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && !clear_i) |=>
            ($stable(match_count_o) && $stable(mismatch_count_o) && $stable(crash_count_o)));

    // R5: a crash comes only out of the watching state
    a_r5_crash_from_watch: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_WATCH) |=> $stable(crash_count_o) || $past(clear_i));

endmodule

// File: tb/test_sig_result_checker.sv
module test_sig_result_checker;

    localparam int unsigned SIG_W = 16;
    localparam int unsigned WIN_W = 16;
    localparam int unsigned CNT_W = 4;
    localparam int unsigned NVEC  = 8;

    // {port data, reference}
    localparam logic [31:0] VEC [NVEC] = '{
        {16'h1234, 16'h1234},
        {16'hBEEF, 16'hBEEF},
        {16'hBEEF, 16'hBEEE},
        {16'h0000, 16'h0000},
        {16'hFFFF, 16'h7FFF},
        {16'hA5A5, 16'h5A5A},
        {16'h0001, 16'h0001},
        {16'hFFFF, 16'hFFFF}
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic             arm_i;
    logic             clear_i;
    logic             strobe_i;
    logic [SIG_W-1:0] port_data_i;
    logic [SIG_W-1:0] ref_sig_i;
    logic [WIN_W-1:0] window_i;
    logic             mismatch_flag_o;
    logic             crash_flag_o;
    logic [1:0]       outcome_o;
    logic [CNT_W-1:0] match_count_o;
    logic [CNT_W-1:0] mismatch_count_o;
    logic [CNT_W-1:0] crash_count_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int exp_ok;
    int exp_bad;

    always #2.5 clk = ~clk;

    sig_result_checker #(
        .SIG_W (SIG_W),
        .WIN_W (WIN_W),
        .CNT_W (CNT_W)
    ) i_sig_result_checker (
        .clk              (clk),
        .rst_n            (rst_n),
        .arm_i            (arm_i),
        .clear_i          (clear_i),
        .strobe_i         (strobe_i),
        .port_data_i      (port_data_i),
        .ref_sig_i        (ref_sig_i),
        .window_i         (window_i),
        .mismatch_flag_o  (mismatch_flag_o),
        .crash_flag_o     (crash_flag_o),
        .outcome_o        (outcome_o),
        .match_count_o    (match_count_o),
        .mismatch_count_o (mismatch_count_o),
        .crash_count_o    (crash_count_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [SIG_W-1:0] d, input int hold);
        @(negedge clk);
        port_data_i = d;
        strobe_i    = 1'b1;
        repeat (hold) @(negedge clk);
        strobe_i = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        clear_i = 1'b1;
        @(negedge clk);
        clear_i = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; arm_i = 1'b0; clear_i = 1'b0; strobe_i = 1'b0;
        port_data_i = '0; ref_sig_i = '0; window_i = 16'd40;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 mismatch flag", mismatch_flag_o, 0);
        chk("R1 crash flag", crash_flag_o, 0);
        chk("R1 outcome", outcome_o, 0);
        chk("R1 match count", match_count_o, 0);
        chk("R1 mismatch count", mismatch_count_o, 0);
        chk("R1 crash count", crash_count_o, 0);

        arm_i = 1'b1;
        repeat (3) @(negedge clk);

        // R3 / R4 table walk
        exp_ok = 0; exp_bad = 0;
        for (int i = 0; i < NVEC; i++) begin
            ref_sig_i = VEC[i][15:0];
            send(VEC[i][31:16], 2);
            if (VEC[i][31:16] == VEC[i][15:0]) exp_ok++;
            else exp_bad++;
            chk("R3 match count", match_count_o, exp_ok);
            chk("R4 mismatch count", mismatch_count_o, exp_bad);
        end
        chk("R4 mismatch flag sticky", mismatch_flag_o, 1);
        chk("R9 outcome wrong first", outcome_o, 1);
        chk("R5 no crash in table", crash_flag_o, 0);

        // R2 long strobe counted once
        ref_sig_i = 16'h4242;
        send(16'h4242, 10);
        chk("R2 long strobe once", match_count_o, exp_ok + 1);

        // R10 clear
        pulse_clear();
        chk("R10 clear mismatch flag", mismatch_flag_o, 0);
        chk("R10 clear outcome", outcome_o, 0);
        chk("R10 clear match count", match_count_o, 0);
        chk("R10 clear mismatch count", mismatch_count_o, 0);

        // R6 strobes inside the window
        window_i = 16'd10;
        for (int i = 0; i < 6; i++) send(16'h4242, 2);
        chk("R6 no crash with reloads", crash_flag_o, 0);
        chk("R6 matches", match_count_o, 6);

        // R5 exact crash timing
        arm_i = 1'b0;
        repeat (2) @(negedge clk);
        pulse_clear();
        arm_i = 1'b1;
        repeat (11) @(negedge clk);
        chk("R5 crash not before window", crash_flag_o, 0);
        @(negedge clk);
        chk("R5 crash after window", crash_flag_o, 1);
        chk("R5 crash count", crash_count_o, 1);
        chk("R9 outcome crash first", outcome_o, 2);
        repeat (30) @(negedge clk);
        chk("R5 one crash per silence", crash_count_o, 1);

        // R7 resume from silence, wrong result keeps crash outcome
        send(16'h0BAD, 2);
        chk("R7 compared after crash", mismatch_count_o, 1);
        chk("R9 outcome kept", outcome_o, 2);
        repeat (14) @(negedge clk);
        chk("R7 second crash", crash_count_o, 2);

        // R8 disarmed: strobes and silence ignored
        arm_i = 1'b0;
        repeat (2) @(negedge clk);
        send(16'h0BAD, 2);
        chk("R8 disarmed strobe ignored", mismatch_count_o, 1);
        repeat (40) @(negedge clk);
        chk("R8 no crash when disarmed", crash_count_o, 2);

        // R10 clear wins over crash at the same edge
        pulse_clear();
        arm_i = 1'b1;
        repeat (11) @(negedge clk);
        clear_i = 1'b1;
        @(negedge clk);
        clear_i = 1'b0;
        chk("R10 clear beats crash flag", crash_flag_o, 0);
        chk("R10 clear beats crash count", crash_count_o, 0);
        chk("R10 clear beats outcome", outcome_o, 0);

        // R11 saturation
        window_i = 16'd40;
        for (int i = 0; i < 18; i++) send(16'h4242, 2);
        chk("R11 match count saturates", match_count_o, 15);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule